// File: doc/BRIEF.md
# Predicted Fetch Group Builder

This block assembles, once per enabled cycle, the bundle of instructions handed from the front end to decode. From the current fetch address it requests the cache line that holds it. When the instruction memory reports a hit, the block picks consecutive words out of that line. For each word it asks a direction predictor and a branch target buffer (BTB) whether control leaves the straight-line path. It then registers a group of up to `FETCH_WIDTH` slots. Each slot carries the instruction word, its address, its predicted successor address and a unique sequence number. The group also carries a count of occupied slots. The fetch address then moves to where the following group begins.

Assembly stops at the earliest of three points: the slot budget is used up, the next word would fall outside the current line, or a slot is predicted taken. A taken prediction counts only if the BTB also holds a valid target for that address. On a miss the block emits nothing and raises a stall until the memory signals that the fill has finished. The next enabled cycle then builds the group from the line without asking the memory again. A redirect input loads a new fetch address and abandons any outstanding miss. A fault reported on a word inside the group truncates the group before that word and latches a sticky error.

Top module: `fgroup_builder`

## Requirements
- R1: On an enabled cycle in the running state with a cache hit, the group appears on the outputs one cycle later. Slot 0 holds the word at the fetch address. The valid bits are contiguous from slot 0, and `grp_count_o` equals the number of set valid bits. `grp_valid_o` is high exactly when the count is non-zero.
- R2: An enabled access that misses produces no group. `miss_stall_o` rises on the next cycle and stays high until the cycle after `imem_fill_done_i` is seen.
- R3: `imem_req_o` is high only on an enabled, non-redirect cycle in the running state. The group built after a completed miss is formed with `imem_req_o` low.
- R4: A slot's predicted next address is the BTB target only when the direction predictor says taken and the BTB entry is valid. Otherwise it is the slot address plus 4, so a taken guess without a valid BTB entry falls through.
- R5: No slot follows a slot that is predicted taken.
- R6: A group holds at most `FETCH_WIDTH` slots, and every slot lies in the 64-byte line of slot 0, where the line offset is address bits [5:0] and instructions are 4 bytes.
- R7: Slot k carries sequence number S+k, where S is the running count of instructions issued in earlier groups. That count advances only by the number of valid slots.
- R8: After a group is built, `fetch_pc_o` equals the predicted next address of the last valid slot, and `fetch_npc_o` is always `fetch_pc_o` + 4.
- R9: When a word within the group's reach is flagged in `imem_fault_i`, the group ends before that word and `err_o` rises and stays high until reset. A fault on the first word yields no group and leaves the fetch address unchanged.
- R10: A redirect loads `redirect_pc_i` into the fetch address, returns the block to the running state (clearing a miss stall) and builds no group that cycle.
- R11: After reset the fetch address is `RESET_PC`, the sequence count is zero, and no group, stall or error is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_en_i | input | 1 | Downstream accepts a group this cycle |
| redirect_i | input | 1 | Load a new fetch address |
| redirect_pc_i | input | ADDR_W | New fetch address |
| imem_req_o | output | 1 | Access request for the line at `imem_addr_o` |
| imem_addr_o | output | ADDR_W | Base address of the line holding the fetch address |
| imem_hit_i | input | 1 | Same-cycle hit indication for the request |
| imem_fill_done_i | input | 1 | Outstanding miss has been filled |
| imem_line_i | input | LINE_BYTES*8 | Line contents, word i at bits [32i+31:32i] |
| imem_fault_i | input | LINE_BYTES/4 | Per-word fault flags for the line |
| pq_pc_o | output | FETCH_WIDTH*ADDR_W | Predictor query address per slot |
| pq_taken_i | input | FETCH_WIDTH | Direction guess per slot |
| btb_hit_i | input | FETCH_WIDTH | BTB entry valid per slot |
| btb_tgt_i | input | FETCH_WIDTH*ADDR_W | BTB target per slot |
| grp_valid_o | output | 1 | A group is presented |
| grp_count_o | output | clog2(FETCH_WIDTH+1) | Occupied slots |
| slot_valid_o | output | FETCH_WIDTH | Per-slot valid |
| slot_inst_o | output | FETCH_WIDTH*32 | Instruction words |
| slot_pc_o | output | FETCH_WIDTH*ADDR_W | Slot addresses |
| slot_npc_o | output | FETCH_WIDTH*ADDR_W | Predicted next addresses |
| slot_seq_o | output | FETCH_WIDTH*SEQ_W | Sequence numbers |
| fetch_pc_o | output | ADDR_W | Current fetch address |
| fetch_npc_o | output | ADDR_W | Fetch address plus 4 |
| miss_stall_o | output | 1 | Waiting for a miss fill |
| err_o | output | 1 | Sticky fault flag |

## Verification
Straight-line fetch from a line start gives full-width groups, and a start near the line end gives short groups. Together these separate the width limit from the line limit. Branch patterns place a taken-with-target guess at slot 0, in the middle and at the last word of a line. They also cover a taken guess with no BTB entry, a BTB entry guessed not taken, and a not-taken branch followed by a taken one. These tell the gating of a prediction apart from the cut that follows it. Miss sequences cover fills followed by idle and then enabled cycles, and a redirect during a stall. Fault placement at the third word and at the first word shows truncation, the held fetch address and the sticky error.

// File: rtl/fgroup_pkg.sv
package fgroup_pkg;
    typedef enum logic [1:0] {
        FG_RUN   = 2'd0,
        FG_WAIT  = 2'd1,
        FG_READY = 2'd2
    } fg_state_e;
endpackage

// File: rtl/fgroup_slot.sv
module fgroup_slot #(
    parameter int ADDR_W     = 32,
    parameter int INST_BYTES = 4,
    parameter int LINE_BYTES = 64,
    parameter int SLOT       = 0
) (
    input  logic [ADDR_W-1:0]                 base_pc_i,
    input  logic [LINE_BYTES*8-1:0]           line_i,
    input  logic [LINE_BYTES/INST_BYTES-1:0]  fault_i,
    input  logic                              dir_taken_i,
    input  logic                              btb_hit_i,
    input  logic [ADDR_W-1:0]                 btb_tgt_i,
    output logic [ADDR_W-1:0]                 pc_o,
    output logic [INST_BYTES*8-1:0]           inst_o,
    output logic [ADDR_W-1:0]                 npc_o,
    output logic                              taken_o,
    output logic                              in_line_o,
    output logic                              faulted_o
);
    localparam int INST_W     = INST_BYTES * 8;
    localparam int LINE_WORDS = LINE_BYTES / INST_BYTES;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int IB_W       = $clog2(INST_BYTES);
    localparam int WIDX_W     = $clog2(LINE_WORDS);

    logic [WIDX_W:0]   widx;
    logic [WIDX_W-1:0] widx_lo;

    always_comb begin
        pc_o      = base_pc_i + ADDR_W'(SLOT * INST_BYTES);
        widx      = {1'b0, base_pc_i[OFF_W-1:IB_W]} + (WIDX_W+1)'(SLOT);
        widx_lo   = widx[WIDX_W-1:0];
        in_line_o = ~widx[WIDX_W];
        inst_o    = line_i[widx_lo*INST_W +: INST_W];
        faulted_o = in_line_o & fault_i[widx_lo];
        taken_o   = dir_taken_i & btb_hit_i;
        npc_o     = taken_o ? btb_tgt_i : pc_o + ADDR_W'(INST_BYTES);
    end
endmodule

// File: rtl/fgroup_trim.sv
module fgroup_trim #(
    parameter int WIDTH  = 4,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = $clog2(WIDTH + 1)
) (
    input  logic              in_line_i [WIDTH],
    input  logic              faulted_i [WIDTH],
    input  logic              taken_i   [WIDTH],
    input  logic [ADDR_W-1:0] npc_i     [WIDTH],
    input  logic [ADDR_W-1:0] cur_pc_i,
    output logic [WIDTH-1:0]  alive_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              fault_seen_o
);
    always_comb begin
        logic reach;
        reach        = 1'b1;
        alive_o      = '0;
        count_o      = '0;
        next_pc_o    = cur_pc_i;
        fault_seen_o = 1'b0;
        for (int k = 0; k < WIDTH; k++) begin
            if (reach && in_line_i[k]) begin
                if (faulted_i[k]) begin
                    fault_seen_o = 1'b1;
                    reach        = 1'b0;
                end else begin
                    alive_o[k] = 1'b1;
                    count_o    = count_o + CNT_W'(1);
                    next_pc_o  = npc_i[k];
                    if (taken_i[k]) reach = 1'b0;
                end
            end else begin
                reach = 1'b0;
            end
        end
    end
endmodule

// File: rtl/fgroup_builder.sv
module fgroup_builder
    import fgroup_pkg::*;
#(
    parameter int                FETCH_WIDTH = 4,
    parameter int                ADDR_W      = 32,
    parameter int                INST_BYTES  = 4,
    parameter int                LINE_BYTES  = 64,
    parameter int                SEQ_W       = 16,
    parameter logic [ADDR_W-1:0] RESET_PC    = '0,
    localparam int INST_W     = INST_BYTES * 8,
    localparam int LINE_WORDS = LINE_BYTES / INST_BYTES,
    localparam int LINE_BITS  = LINE_BYTES * 8,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int CNT_W      = $clog2(FETCH_WIDTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fetch_en_i,
    input  logic                          redirect_i,
    input  logic [ADDR_W-1:0]             redirect_pc_i,
    output logic                          imem_req_o,
    output logic [ADDR_W-1:0]             imem_addr_o,
    input  logic                          imem_hit_i,
    input  logic                          imem_fill_done_i,
    input  logic [LINE_BITS-1:0]          imem_line_i,
    input  logic [LINE_WORDS-1:0]         imem_fault_i,
    output logic [FETCH_WIDTH*ADDR_W-1:0] pq_pc_o,
    input  logic [FETCH_WIDTH-1:0]        pq_taken_i,
    input  logic [FETCH_WIDTH-1:0]        btb_hit_i,
    input  logic [FETCH_WIDTH*ADDR_W-1:0] btb_tgt_i,
    output logic                          grp_valid_o,
    output logic [CNT_W-1:0]              grp_count_o,
    output logic [FETCH_WIDTH-1:0]        slot_valid_o,
    output logic [FETCH_WIDTH*INST_W-1:0] slot_inst_o,
    output logic [FETCH_WIDTH*ADDR_W-1:0] slot_pc_o,
    output logic [FETCH_WIDTH*ADDR_W-1:0] slot_npc_o,
    output logic [FETCH_WIDTH*SEQ_W-1:0]  slot_seq_o,
    output logic [ADDR_W-1:0]             fetch_pc_o,
    output logic [ADDR_W-1:0]             fetch_npc_o,
    output logic                          miss_stall_o,
    output logic                          err_o
);
    typedef struct packed {
        fg_state_e                     st;
        logic [ADDR_W-1:0]             pc;
        logic [SEQ_W-1:0]              seq;
        logic                          err;
        logic                          gv;
        logic [CNT_W-1:0]              cnt;
        logic [FETCH_WIDTH-1:0]        sv;
        logic [FETCH_WIDTH*INST_W-1:0] inst;
        logic [FETCH_WIDTH*ADDR_W-1:0] spc;
        logic [FETCH_WIDTH*ADDR_W-1:0] snpc;
        logic [FETCH_WIDTH*SEQ_W-1:0]  sseq;
    } fg_regs_t;

    fg_regs_t r_q, r_d;

    // per-slot evaluation results
    logic [ADDR_W-1:0] s_pc      [FETCH_WIDTH];
    logic [INST_W-1:0] s_inst    [FETCH_WIDTH];
    logic [ADDR_W-1:0] s_npc     [FETCH_WIDTH];
    logic              s_taken   [FETCH_WIDTH];
    logic              s_in_line [FETCH_WIDTH];
    logic              s_faulted [FETCH_WIDTH];

    logic [FETCH_WIDTH-1:0] t_alive;
    logic [CNT_W-1:0]       t_count;
    logic [ADDR_W-1:0]      t_next_pc;
    logic                   t_fault;
    logic                   build;
    logic                   req;

    for (genvar k = 0; k < FETCH_WIDTH; k++) begin : g_slot
        fgroup_slot #(
            .ADDR_W     (ADDR_W),
            .INST_BYTES (INST_BYTES),
            .LINE_BYTES (LINE_BYTES),
            .SLOT       (k)
        ) u_slot (
            .base_pc_i   (r_q.pc),
            .line_i      (imem_line_i),
            .fault_i     (imem_fault_i),
            .dir_taken_i (pq_taken_i[k]),
            .btb_hit_i   (btb_hit_i[k]),
            .btb_tgt_i   (btb_tgt_i[k*ADDR_W +: ADDR_W]),
            .pc_o        (s_pc[k]),
            .inst_o      (s_inst[k]),
            .npc_o       (s_npc[k]),
            .taken_o     (s_taken[k]),
            .in_line_o   (s_in_line[k]),
            .faulted_o   (s_faulted[k])
        );
        assign pq_pc_o[k*ADDR_W +: ADDR_W] = s_pc[k];
    end

    fgroup_trim #(
        .WIDTH  (FETCH_WIDTH),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_trim (
        .in_line_i    (s_in_line),
        .faulted_i    (s_faulted),
        .taken_i      (s_taken),
        .npc_i        (s_npc),
        .cur_pc_i     (r_q.pc),
        .alive_o      (t_alive),
        .count_o      (t_count),
        .next_pc_o    (t_next_pc),
        .fault_seen_o (t_fault)
    );

    always_comb begin
        r_d      = r_q;
        r_d.gv   = 1'b0;
        r_d.cnt  = '0;
        r_d.sv   = '0;
        r_d.inst = '0;
        r_d.spc  = '0;
        r_d.snpc = '0;
        r_d.sseq = '0;
        build    = 1'b0;
        req      = 1'b0;

        if (redirect_i) begin
            r_d.pc = redirect_pc_i;
            r_d.st = FG_RUN;
        end else begin
            case (r_q.st)
                FG_RUN: begin
                    if (fetch_en_i) begin
                        req = 1'b1;
                        if (imem_hit_i) build  = 1'b1;
                        else            r_d.st = FG_WAIT;
                    end
                end
                FG_WAIT: begin
                    if (imem_fill_done_i) r_d.st = FG_READY;
                end
                FG_READY: begin
                    if (fetch_en_i) begin
                        build  = 1'b1;
                        r_d.st = FG_RUN;
                    end
                end
                default: r_d.st = FG_RUN;
            endcase
        end

        if (build) begin
            r_d.gv  = (t_count != '0);
            r_d.cnt = t_count;
            r_d.sv  = t_alive;
            for (int k = 0; k < FETCH_WIDTH; k++) begin
                if (t_alive[k]) begin
                    r_d.inst[k*INST_W +: INST_W] = s_inst[k];
                    r_d.spc [k*ADDR_W +: ADDR_W] = s_pc[k];
                    r_d.snpc[k*ADDR_W +: ADDR_W] = s_npc[k];
                    r_d.sseq[k*SEQ_W  +: SEQ_W ] = r_q.seq + SEQ_W'(k);
                end
            end
            r_d.seq = r_q.seq + SEQ_W'(t_count);
            r_d.pc  = t_next_pc;
            r_d.err = r_q.err | t_fault;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= FG_RUN;
            r_q.pc <= RESET_PC;
        end else begin
            r_q <= r_d;
        end
    end

    assign imem_req_o   = req;
    assign imem_addr_o  = {r_q.pc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign grp_valid_o  = r_q.gv;
    assign grp_count_o  = r_q.cnt;
    assign slot_valid_o = r_q.sv;
    assign slot_inst_o  = r_q.inst;
    assign slot_pc_o    = r_q.spc;
    assign slot_npc_o   = r_q.snpc;
    assign slot_seq_o   = r_q.sseq;
    assign fetch_pc_o   = r_q.pc;
    assign fetch_npc_o  = r_q.pc + ADDR_W'(INST_BYTES);
    assign miss_stall_o = (r_q.st == FG_WAIT);
    assign err_o        = r_q.err;
endmodule

// File: rtl/fgroup_chk.sv
module fgroup_chk #(
    parameter int FETCH_WIDTH = 4,
    parameter int ADDR_W      = 32,
    parameter int SEQ_W       = 16,
    parameter int LINE_BYTES  = 64,
    parameter int CNT_W       = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          imem_req_o,
    input logic                          imem_hit_i,
    input logic                          miss_stall_o,
    input logic                          grp_valid_o,
    input logic [CNT_W-1:0]              grp_count_o,
    input logic [FETCH_WIDTH-1:0]        slot_valid_o,
    input logic [FETCH_WIDTH*ADDR_W-1:0] slot_pc_o,
    input logic [FETCH_WIDTH*ADDR_W-1:0] slot_npc_o,
    input logic [FETCH_WIDTH*SEQ_W-1:0]  slot_seq_o,
    input logic [ADDR_W-1:0]             fetch_pc_o,
    input logic                          err_o
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(grp_count_o) <= FETCH_WIDTH);

    p_count_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_valid_o) == int'(grp_count_o));

    p_valid_slot0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid_o == slot_valid_o[0]);

    p_no_req_waiting_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_stall_o |-> !imem_req_o);

    p_miss_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_req_o && !imem_hit_i) |=> (miss_stall_o && !grp_valid_o));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    p_pc_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid_o |->
            fetch_pc_o == slot_npc_o[(int'(grp_count_o) - 1)*ADDR_W +: ADDR_W]);

    for (genvar k = 1; k < FETCH_WIDTH; k++) begin : g_pair
        p_seq_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid_o[k] |->
                slot_seq_o[k*SEQ_W +: SEQ_W] == slot_seq_o[(k-1)*SEQ_W +: SEQ_W] + SEQ_W'(1));

        p_same_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid_o[k] |->
                slot_pc_o[k*ADDR_W+OFF_W +: ADDR_W-OFF_W] == slot_pc_o[OFF_W +: ADDR_W-OFF_W]);

        p_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid_o[k] |->
                (slot_valid_o[k-1] &&
                 slot_npc_o[(k-1)*ADDR_W +: ADDR_W] == slot_pc_o[k*ADDR_W +: ADDR_W]));
    end
endmodule

bind fgroup_builder fgroup_chk #(
    .FETCH_WIDTH (FETCH_WIDTH),
    .ADDR_W      (ADDR_W),
    .SEQ_W       (SEQ_W),
    .LINE_BYTES  (LINE_BYTES),
    .CNT_W       (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .imem_req_o   (imem_req_o),
    .imem_hit_i   (imem_hit_i),
    .miss_stall_o (miss_stall_o),
    .grp_valid_o  (grp_valid_o),
    .grp_count_o  (grp_count_o),
    .slot_valid_o (slot_valid_o),
    .slot_pc_o    (slot_pc_o),
    .slot_npc_o   (slot_npc_o),
    .slot_seq_o   (slot_seq_o),
    .fetch_pc_o   (fetch_pc_o),
    .err_o        (err_o)
);

// File: tb/fgroup_builder_bench.sv
`timescale 1ns/1ps
module fgroup_builder_bench;
    localparam int W  = 4;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          fetch_en = 0, redirect = 0, imem_hit = 0, fill_done = 0;
    logic [AW-1:0] redirect_pc = '0;
    logic          imem_req_o;
    logic [AW-1:0] imem_addr_o;
    logic [511:0]  line_v;
    logic [15:0]   fault_v;
    logic [W*AW-1:0] pq_pc_o;
    logic [W-1:0]    pq_taken, btb_hit;
    logic [W*AW-1:0] btb_tgt;
    logic          grp_valid_o;
    logic [2:0]    grp_count_o;
    logic [W-1:0]  slot_valid_o;
    logic [W*32-1:0] slot_inst_o;
    logic [W*AW-1:0] slot_pc_o, slot_npc_o;
    logic [W*16-1:0] slot_seq_o;
    logic [AW-1:0] fetch_pc_o, fetch_npc_o;
    logic          miss_stall_o, err_o;

    // branch and fault configuration
    logic [31:0] bA_pc = 32'hFFFF_FF00, bA_tgt = '0, bB_pc = 32'hFFFF_FF80, bB_tgt = '0;
    logic        bA_dir = 0, bA_btb = 0, bB_dir = 0, bB_btb = 0;
    logic        f_en = 0;
    logic [31:0] f_addr = '0;

    fgroup_builder u_fgroup_builder (
        .clk (clk), .rst_n (rst_n), .fetch_en_i (fetch_en),
        .redirect_i (redirect), .redirect_pc_i (redirect_pc),
        .imem_req_o (imem_req_o), .imem_addr_o (imem_addr_o),
        .imem_hit_i (imem_hit), .imem_fill_done_i (fill_done),
        .imem_line_i (line_v), .imem_fault_i (fault_v),
        .pq_pc_o (pq_pc_o), .pq_taken_i (pq_taken), .btb_hit_i (btb_hit),
        .btb_tgt_i (btb_tgt), .grp_valid_o (grp_valid_o),
        .grp_count_o (grp_count_o), .slot_valid_o (slot_valid_o),
        .slot_inst_o (slot_inst_o), .slot_pc_o (slot_pc_o),
        .slot_npc_o (slot_npc_o), .slot_seq_o (slot_seq_o),
        .fetch_pc_o (fetch_pc_o), .fetch_npc_o (fetch_npc_o),
        .miss_stall_o (miss_stall_o), .err_o (err_o)
    );

    // environment: memory line, fault flags, predictor responses
    always_comb begin
        for (int i = 0; i < 16; i++) begin
            logic [31:0] a;
            a = imem_addr_o + 32'(4 * i);
            line_v[i*32 +: 32] = {a[15:0], ~a[15:0]};
            fault_v[i] = f_en && (a == f_addr);
        end
        for (int k = 0; k < W; k++) begin
            logic [31:0] q;
            q = pq_pc_o[k*AW +: AW];
            pq_taken[k] = (q == bA_pc && bA_dir) || (q == bB_pc && bB_dir);
            btb_hit[k]  = (q == bA_pc && bA_btb) || (q == bB_pc && bB_btb);
            btb_tgt[k*AW +: AW] = (q == bA_pc) ? bA_tgt : bB_tgt;
        end
    end

    // reference model state
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;
    logic [31:0] m_pc = '0;
    int          m_seq = 0;
    int          m_st = 0;   // 0 run, 1 waiting for fill, 2 fill done
    logic        m_err = 0;
    logic        e_gv = 0;
    int          e_cnt = 0;
    logic [31:0] e_pc [W], e_inst [W], e_npc [W];
    int          e_seq [W];

    function automatic logic [31:0] m_word(logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction
    function automatic bit m_taken(logic [31:0] a);
        return (a == bA_pc && bA_dir && bA_btb) || (a == bB_pc && bB_dir && bB_btb);
    endfunction
    function automatic logic [31:0] m_tgt(logic [31:0] a);
        return (a == bA_pc) ? bA_tgt : bB_tgt;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic m_build();
        logic [31:0] p, base;
        int n;
        bit stop;
        p = m_pc; base = m_pc & ~32'h3F; n = 0; stop = 0;
        while (!stop && n < W) begin
            if ((p & ~32'h3F) != base) stop = 1;
            else if (f_en && p == f_addr) begin m_err = 1; stop = 1; end
            else begin
                e_pc[n]   = p;
                e_inst[n] = m_word(p);
                e_npc[n]  = m_taken(p) ? m_tgt(p) : p + 4;
                e_seq[n]  = m_seq + n;
                n++;
                if (m_taken(p)) stop = 1; else p = p + 4;
            end
        end
        e_cnt = n;
        e_gv  = (n > 0);
        m_seq = m_seq + n;
        if (n > 0) m_pc = e_npc[n-1];
    endtask

    task automatic compare(input bit was_redirect);
        chk("R1 grp_valid", 32'(grp_valid_o), 32'(e_gv));
        chk("R1 grp_count", 32'(grp_count_o), 32'(e_cnt));
        chk("R2 R10 miss_stall", 32'(miss_stall_o), 32'(m_st == 1));
        chk("R9 err sticky", 32'(err_o), 32'(m_err));
        chk(was_redirect ? "R10 fetch_pc" : "R8 fetch_pc", fetch_pc_o, m_pc);
        chk("R8 fetch_npc", fetch_npc_o, m_pc + 4);
        for (int k = 0; k < W; k++) begin
            chk("R5 R6 slot_valid", 32'(slot_valid_o[k]), 32'(k < e_cnt));
            if (k < e_cnt) begin
                chk("R1 R6 slot_pc", slot_pc_o[k*AW +: AW], e_pc[k]);
                chk("R1 slot_inst", slot_inst_o[k*32 +: 32], e_inst[k]);
                chk("R4 slot_npc", slot_npc_o[k*AW +: AW], e_npc[k]);
                chk("R7 slot_seq", 32'(slot_seq_o[k*16 +: 16]), 32'(e_seq[k] & 16'hFFFF));
            end
        end
    endtask

    task automatic step(input bit en, input bit red, input logic [31:0] rpc,
                        input bit hit, input bit fill);
        fetch_en = en; redirect = red; redirect_pc = rpc;
        imem_hit = hit; fill_done = fill;
        #1;
        chk("R3 imem_req", 32'(imem_req_o), 32'(!red && m_st == 0 && en));
        e_gv = 0; e_cnt = 0;
        if (red) begin
            m_pc = rpc; m_st = 0;
        end else begin
            case (m_st)
                0: if (en) begin if (hit) m_build(); else m_st = 1; end
                1: if (fill) m_st = 2;
                2: if (en) begin m_build(); m_st = 0; end
                default: m_st = 0;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        compare(red);
    endtask

    task automatic go(input logic [31:0] pc);
        step(0, 1, pc, 1, 0);
    endtask

    task automatic clear_br();
        bA_pc = 32'hFFFF_FF00; bA_dir = 0; bA_btb = 0;
        bB_pc = 32'hFFFF_FF80; bB_dir = 0; bB_btb = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset grp_valid", 32'(grp_valid_o), 0);
        chk("R11 reset stall", 32'(miss_stall_o), 0);
        chk("R11 reset err", 32'(err_o), 0);
        chk("R11 reset fetch_pc", fetch_pc_o, 32'h0);
        chk("R11 reset slot_valid", 32'(slot_valid_o), 0);

        // straight-line fetch from a line start: full width groups
        go(32'h1000);
        repeat (3) step(1, 0, 0, 1, 0);
        // start near line end: short group, then next line
        go(32'h1038);
        step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        // idle cycles leave everything untouched
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);

        // taken branch with valid target mid group
        bA_pc = 32'h2004; bA_dir = 1; bA_btb = 1; bA_tgt = 32'h3008;
        go(32'h2000);
        step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        // taken guess without target entry: falls through
        bA_btb = 0;
        go(32'h2000);
        step(1, 0, 0, 1, 0);
        // target present but not-taken guess
        bA_dir = 0; bA_btb = 1;
        go(32'h2000);
        step(1, 0, 0, 1, 0);
        // taken at slot 0
        bA_pc = 32'h5000; bA_dir = 1; bA_btb = 1; bA_tgt = 32'h5100;
        go(32'h5000);
        step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        // taken at the last word of a line
        bA_pc = 32'h503C; bA_tgt = 32'h6F00;
        go(32'h5038);
        step(1, 0, 0, 1, 0);
        // not-taken branch followed by a taken one
        bA_pc = 32'h9004; bA_dir = 0; bA_btb = 1;
        bB_pc = 32'h9008; bB_dir = 1; bB_btb = 1; bB_tgt = 32'h9200;
        go(32'h9000);
        step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        clear_br();

        // miss, wait, fill, idle, then build without a request
        go(32'h6000);
        step(1, 0, 0, 0, 0);
        repeat (3) step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 1);
        step(0, 0, 0, 1, 0);
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0);
        // redirect abandons a pending miss
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0);
        go(32'h7000);
        step(1, 0, 0, 1, 0);

        // fault at the third word, then at the first word
        f_en = 1; f_addr = 32'h8008;
        go(32'h8000);
        step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        f_en = 0;
        step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule